// File: doc/BRIEF.md
# Cascadable Segment Line Capture

This block collects one display line of column data for a chain of LCD segment drivers. Each chip in the chain owns a 160-bit line latch, filled one byte at a time from a shared data bus. The bus carries either a full byte or a 4-bit nibble on each shift-clock tick. A line pulse re-arms every chip in the chain. A chip then sits idle until its enable input is raised by the previous chip, or by the controller for the first chip. From that point it takes every tick until its 20 byte slots are full. It then hands the enable on to the next chip with a one-cycle pulse and drops out of the selection.

In nibble mode the block packs two consecutive nibbles into one byte. A one-hot slot pointer steers each finished byte into the next 8-bit field of the latch. The pointer walks either from the low slot upward or from the high slot downward, so a board can mirror its column order without rewiring the bus. All activity is synchronous to `clk`. A shift-clock edge is presented as a one-cycle `shiftTick` qualifier.

Top module: `segLineCapture`

## Requirements
- R1: Out of reset, `lineLatch` is all zeros, `chainEnOut` is low, and the block waits for an enable.
- R2: While the block waits for an enable, ticks on `shiftTick` leave `lineLatch` unchanged. The same holds after a line pulse. A high `linePulse` at a clock edge returns the block to the waiting state and takes no data in that cycle.
- R3: The block becomes selected at the first edge where `chainEnIn` is high while it waits. A tick in that same cycle is already accepted as data.
- R4: With `wideMode` = 1, each accepted tick writes `dataIn[7:0]` into one slot.
- R5: With `wideMode` = 0, only `dataIn[3:0]` is used. The first accepted nibble of a pair becomes bits 7:4 of the byte and the second becomes bits 3:0. The byte is written on the second tick.
- R6: Slot k occupies `lineLatch[8k+7:8k]`. With `dirRtl` = 0 sampled at selection, bytes fill slots 0, 1, 2 … 19 in order.
- R7: With `dirRtl` = 1 sampled at selection, bytes fill slots 19, 18 … 0 in order.
- R8: The edge that writes the 20th byte makes `chainEnOut` high for exactly one cycle, visible right after that edge. At the same edge the block becomes non-selected.
- R9: After the line is complete, further ticks and enables leave `lineLatch` unchanged and `chainEnOut` low until the next line pulse.
- R10: A line pulse during a load aborts it and keeps the bytes already written. The next load starts again at the start slot of its direction, with the nibble pairing reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| linePulse | input | 1 | Line pulse; re-arms capture at the edge where it is high |
| chainEnIn | input | 1 | Enable from the previous chip in the chain |
| shiftTick | input | 1 | One-cycle qualifier marking a shift-clock edge |
| wideMode | input | 1 | 1 = byte per tick, 0 = nibble per tick |
| dirRtl | input | 1 | 0 = fill from slot 0 upward, 1 = from slot 19 downward |
| dataIn | input | 8 | Bus data; only bits 3:0 are used in nibble mode |
| chainEnOut | output | 1 | One-cycle enable pulse to the next chip |
| lineLatch | output | 160 | Captured line, slot k at bits 8k+7:8k |

## Verification
The block has one register stage between a tick and its effect, so every latch write and every enable pulse is due right after the rising edge that samples the tick. The bench drives inputs on falling edges and compares outputs on the following falling edge. At that point a behavioural reference model has applied the same edge. The single-cycle width of the enable pulse is checked on the next falling edge. Checks that something was ignored read the latch one falling edge after the ignored tick and again just before the next line pulse.

// File: rtl/segCapPkg.sv
`timescale 1ns/1ps
package segCapPkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SEL  = 2'd1,
    ST_DONE = 2'd2
  } capState_e;

  // Strobes from the sequencer to the byte path
  typedef struct packed {
    logic restart;
    logic holdHi;
    logic writeByte;
    logic wide;
  } capStrobe_t;

endpackage

// File: rtl/segCapCtrl.sv
`timescale 1ns/1ps
module segCapCtrl
  import segCapPkg::*;
#(
  parameter int SLOTS = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             linePulse,
  input  logic             chainEnIn,
  input  logic             shiftTick,
  input  logic             wideMode,
  input  logic             dirRtl,
  output capStrobe_t       strobes,
  output logic [SLOTS-1:0] slotHot,
  output logic             chainEnOut
);

  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [SLOTS-1:0] FIRST_LTR = {{(SLOTS-1){1'b0}}, 1'b1};
  localparam logic [SLOTS-1:0] FIRST_RTL = {1'b1, {(SLOTS-1){1'b0}}};
  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(SLOTS - 1);

  capState_e        state;
  logic [CNT_W-1:0] count;
  logic             half;
  logic             dirQ;
  logic [SLOTS-1:0] ptr;

  logic             enterNow;
  logic             selected;
  logic             accept;
  logic             curDir;
  logic             lastByte;
  logic [SLOTS-1:0] startHot;
  logic [SLOTS-1:0] nextPtr;

  always_comb begin
    enterNow = (state == ST_WAIT) && chainEnIn;
    selected = (state == ST_SEL) || enterNow;
    accept   = selected && shiftTick && !linePulse;
    startHot = dirRtl ? FIRST_RTL : FIRST_LTR;
    curDir   = enterNow ? dirRtl : dirQ;
    slotHot  = (state == ST_WAIT) ? startHot : ptr;
    nextPtr  = curDir ? {slotHot[0], slotHot[SLOTS-1:1]}
                      : {slotHot[SLOTS-2:0], slotHot[SLOTS-1]};

    strobes.restart   = linePulse;
    strobes.wide      = wideMode;
    strobes.writeByte = accept && (wideMode || half);
    strobes.holdHi    = accept && !wideMode && !half;
    lastByte          = strobes.writeByte && (count == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_WAIT;
      count      <= '0;
      half       <= 1'b0;
      dirQ       <= 1'b0;
      ptr        <= FIRST_LTR;
      chainEnOut <= 1'b0;
    end else begin
      chainEnOut <= lastByte;
      if (linePulse) begin
        state <= ST_WAIT;
        count <= '0;
        half  <= 1'b0;
        ptr   <= startHot;
      end else begin
        if (state == ST_WAIT) ptr <= startHot;
        if (enterNow) begin
          state <= ST_SEL;
          dirQ  <= dirRtl;
        end
        if (strobes.holdHi) half <= 1'b1;
        if (strobes.writeByte) begin
          half  <= 1'b0;
          ptr   <= nextPtr;
          count <= count + 1'b1;
          if (lastByte) begin
            state <= ST_DONE;
            count <= '0;
          end
        end
      end
    end
  end

  // R6 R7: the slot pointer always names exactly one slot
  p_ptr_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ptr) == 1);

  // R8: the byte count never runs past the slot count
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count < CNT_W'(SLOTS));

  // R8: the enable pulse lasts a single cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    chainEnOut |=> !chainEnOut);

  // R8: the enable pulse only appears once the chip has dropped out
  p_pulse_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    chainEnOut |-> (state == ST_DONE));

  // R2: a line pulse re-arms and silences the chain output
  p_lp_rearm_r2: assert property (@(posedge clk) disable iff (!rstN)
    linePulse |=> ((state == ST_WAIT) && !chainEnOut));

  // R9: a finished chip stays quiet until the next line pulse
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DONE) && !linePulse) |=> ((state == ST_DONE) && !chainEnOut));

  // R2 R9: no write strobe unless selected
  p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((state != ST_SEL) && !chainEnIn) |-> !strobes.writeByte);

endmodule

// File: rtl/segCapPath.sv
`timescale 1ns/1ps
module segCapPath
  import segCapPkg::*;
#(
  parameter int SLOTS  = 20,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  capStrobe_t              strobes,
  input  logic [SLOTS-1:0]        slotHot,
  input  logic [BYTE_W-1:0]       dataIn,
  output logic [SLOTS*BYTE_W-1:0] lineLatch
);

  localparam int NIB_W = BYTE_W / 2;

  logic [NIB_W-1:0]  hiNib;
  logic [BYTE_W-1:0] byteVal;

  always_comb begin
    byteVal = strobes.wide ? dataIn : {hiNib, dataIn[NIB_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiNib <= '0;
    end else if (strobes.holdHi) begin
      hiNib <= dataIn[NIB_W-1:0];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineLatch[k*BYTE_W +: BYTE_W] <= '0;
      end else if (strobes.writeByte && slotHot[k]) begin
        lineLatch[k*BYTE_W +: BYTE_W] <= byteVal;
      end
    end
  end

  // R9 R2: the latch moves only under a write strobe
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.writeByte |=> $stable(lineLatch));

  // R5: a nibble is never held and written in the same cycle
  p_nib_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.holdHi && strobes.writeByte));

endmodule

// File: rtl/segLineCapture.sv
`timescale 1ns/1ps
module segLineCapture
  import segCapPkg::*;
#(
  parameter int SLOTS  = 20,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    linePulse,
  input  logic                    chainEnIn,
  input  logic                    shiftTick,
  input  logic                    wideMode,
  input  logic                    dirRtl,
  input  logic [BYTE_W-1:0]       dataIn,
  output logic                    chainEnOut,
  output logic [SLOTS*BYTE_W-1:0] lineLatch
);

  capStrobe_t       strobes;
  logic [SLOTS-1:0] slotHot;

  segCapCtrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .linePulse (linePulse),
    .chainEnIn (chainEnIn),
    .shiftTick (shiftTick),
    .wideMode  (wideMode),
    .dirRtl    (dirRtl),
    .strobes   (strobes),
    .slotHot   (slotHot),
    .chainEnOut(chainEnOut)
  );

  segCapPath #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .slotHot   (slotHot),
    .dataIn    (dataIn),
    .lineLatch (lineLatch)
  );

endmodule

// File: tb/segLineCapture_test.sv
`timescale 1ns/1ps
module segLineCapture_test;

  localparam int SL = 20;
  localparam int LW = SL * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          linePulse = 1'b0;
  logic          chainEnIn = 1'b0;
  logic          shiftTick = 1'b0;
  logic          wideMode = 1'b1;
  logic          dirRtl = 1'b0;
  logic [7:0]    dataIn = 8'h00;
  logic          chainEnOut;
  logic [LW-1:0] lineLatch;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  segLineCapture uut (
    .clk(clk), .rstN(rstN), .linePulse(linePulse), .chainEnIn(chainEnIn),
    .shiftTick(shiftTick), .wideMode(wideMode), .dirRtl(dirRtl),
    .dataIn(dataIn), .chainEnOut(chainEnOut), .lineLatch(lineLatch)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: 0 waiting, 1 selected, 2 finished
  int            mState = 0;
  int            mCnt = 0;
  bit            mHalf = 0;
  bit            mDir = 0;
  logic [3:0]    mHi = '0;
  logic [LW-1:0] mLine = '0;
  bit            mPulse = 0;

  always @(posedge clk) begin
    bit sel;
    bit nextPulse;
    int slot;
    nextPulse = 0;
    if (!rstN) begin
      mState = 0; mCnt = 0; mHalf = 0; mDir = 0; mLine = '0;
    end else if (linePulse) begin
      mState = 0; mCnt = 0; mHalf = 0;
    end else begin
      sel = (mState == 1) || (mState == 0 && chainEnIn);
      if (mState == 0 && chainEnIn) begin
        mState = 1;
        mDir = dirRtl;
      end
      if (sel && shiftTick) begin
        if (wideMode || mHalf) begin
          slot = mDir ? (SL - 1 - mCnt) : mCnt;
          mLine[slot*8 +: 8] = wideMode ? dataIn : {mHi, dataIn[3:0]};
          mHalf = 0;
          mCnt++;
          if (mCnt == SL) begin
            mState = 2; mCnt = 0; nextPulse = 1;
          end
        end else begin
          mHi = dataIn[3:0];
          mHalf = 1;
        end
      end
    end
    mPulse = nextPulse;
  end

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R8", LW'(chainEnOut), LW'(mPulse));
      chk(curReq, lineLatch, mLine);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input logic [7:0] d, input logic en);
    @(negedge clk);
    shiftTick = 1'b1; dataIn = d; chainEnIn = en;
    @(negedge clk);
    shiftTick = 1'b0; chainEnIn = 1'b0;
  endtask

  task automatic pulseLine();
    @(negedge clk);
    linePulse = 1'b1;
    @(negedge clk);
    linePulse = 1'b0;
  endtask

  function automatic logic [7:0] slotOf(input logic [LW-1:0] l, input int k);
    return l[k*8 +: 8];
  endfunction

  initial begin
    logic [LW-1:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", lineLatch, '0);
    chk("R1", LW'(chainEnOut), '0);

    // R2 ticks with no enable are ignored
    curReq = "R2";
    for (int i = 0; i < 4; i++) tick(8'hE0 + 8'(i), 1'b0);
    chk("R2", lineLatch, '0);

    // R3 R4 R6 byte mode, upward, enable in the same cycle as the first tick
    curReq = "R6";
    wideMode = 1'b1; dirRtl = 1'b0;
    tick(8'h10, 1'b1);
    chk("R3", LW'(slotOf(lineLatch, 0)), LW'(8'h10));
    for (int k = 1; k < SL; k++) begin
      tick(8'h10 + 8'(k), 1'b0);
      if (k == SL - 1) chk("R8", LW'(chainEnOut), LW'(1'b1));
    end
    @(negedge clk);
    chk("R8", LW'(chainEnOut), '0);
    for (int k = 0; k < SL; k++) chk("R4", LW'(slotOf(lineLatch, k)), LW'(8'h10 + 8'(k)));

    // R9 finished chip ignores ticks and enables
    curReq = "R9";
    snap = lineLatch;
    for (int i = 0; i < 3; i++) tick(8'hFF, 1'b1);
    chk("R9", lineLatch, snap);
    chk("R9", LW'(chainEnOut), '0);

    // R2 after a line pulse, no data until enabled
    pulseLine();
    curReq = "R2";
    tick(8'h33, 1'b0);
    chk("R2", lineLatch, snap);

    // R5 R7 nibble mode, downward; upper bits of the bus must be ignored
    curReq = "R7";
    wideMode = 1'b0; dirRtl = 1'b1;
    @(negedge clk); chainEnIn = 1'b1;
    @(negedge clk); chainEnIn = 1'b0;
    for (int k = 0; k < SL; k++) begin
      logic [7:0] b;
      b = 8'hA0 + 8'(k);
      tick({4'hF, b[7:4]}, 1'b0);
      tick({4'h5, b[3:0]}, 1'b0);
      if (k == SL - 1) chk("R8", LW'(chainEnOut), LW'(1'b1));
    end
    for (int k = 0; k < SL; k++) chk("R5", LW'(slotOf(lineLatch, SL - 1 - k)), LW'(8'hA0 + 8'(k)));

    // R10 abort mid-load keeps partial bytes, restart from slot 0
    curReq = "R10";
    pulseLine();
    wideMode = 1'b1; dirRtl = 1'b0;
    tick(8'h50, 1'b1);
    for (int k = 1; k < 5; k++) tick(8'h50 + 8'(k), 1'b0);
    pulseLine();
    for (int k = 0; k < 5; k++) chk("R10", LW'(slotOf(lineLatch, k)), LW'(8'h50 + 8'(k)));
    chk("R10", LW'(slotOf(lineLatch, 5)), LW'(8'hA0 + 8'(SL - 1 - 5)));
    tick(8'h70, 1'b1);
    tick(8'h71, 1'b0);
    tick(8'h72, 1'b0);
    chk("R10", LW'(slotOf(lineLatch, 0)), LW'(8'h70));
    chk("R10", LW'(slotOf(lineLatch, 2)), LW'(8'h72));
    chk("R10", LW'(slotOf(lineLatch, 3)), LW'(8'h53));

    // R10 abort between nibbles resets the pairing
    pulseLine();
    wideMode = 1'b0;
    tick(8'h0C, 1'b1);
    pulseLine();
    tick(8'h03, 1'b1);
    tick(8'h09, 1'b0);
    chk("R10", LW'(slotOf(lineLatch, 0)), LW'(8'h39));

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule